// File: doc/BRIEF.md
# Boot and Debug Start-up Sequencer

This controller decides what a small processor core does after reset and carries out the commands of an external debugger. While reset is held, two strap pins are captured. Their value selects one of three start-up paths. The core can sit halted and wait for a debugger. It can take a program image pushed in by a host through an SPI slave shifter. It can also fetch the image itself from a serial flash through an SPI master shifter. In both load paths the controller packs incoming bytes into instruction words and writes them to the instruction memory. Once the last byte of the image has been stored, it sets the core running.

The controller does not depend on the core's design. Its only outputs to the core are a run level, a single-cycle step pulse and a halt level, plus the write strobe, address and data of the instruction memory. The shifters, the core and the memories sit outside it.

Debugger commands come from a slower, unrelated clock domain. They cross into the core domain through a request/acknowledge handshake built on a flop synchroniser. A command is honoured only in the state where it makes sense. For example, an image load or a single step is accepted only while the core is stopped.

Top module: `boot_seq_ctrl`

## Requirements
- R1: The strap value `mode_pins` is captured while `rst_n` is low. After reset, 2'b00 and 2'b11 leave the core halted and waiting for the debugger, 2'b01 starts an SPI-slave image load, and 2'b10 starts a flash image load with `flash_sel` high.
- R2: During a load, received bytes are paired in big-endian order (the first byte becomes bits 15:8). Each pair produces exactly one `imem_we` cycle, at word addresses 0, 1, 2 … 255 in order. A 512-byte image therefore produces 256 writes.
- R3: When a load started by the strap pins stores its last byte, `core_run` goes high without any debugger action.
- R4: A flash load first sends four header bytes on `tx_data`: 8'h03 followed by three 8'h00 address bytes. Each byte is held with `tx_valid` high until `tx_ack` is seen, and only then are image bytes accepted.
- R5: `flash_sel` stays high from the header until the last image byte, then falls.
- R6: Debugger commands use a four-phase handshake. `dbg_ack` follows `dbg_req` through the synchroniser, and each rising request executes its command exactly once. Command codes: 1 RESET, 2 LOAD, 3 START, 4 STEP, 5 STOP. Other codes do nothing.
- R7: START moves a halted core to running and STOP moves a running core to halted. `core_halt` is always the inverse of `core_run`.
- R8: STEP from the halted state gives exactly one cycle of `core_step` and leaves the core halted. STEP while running is ignored.
- R9: LOAD from the halted state performs an SPI-slave image load and ends halted, without starting the core. LOAD while running is ignored, so no writes happen.
- R10: RESET from any state halts the core, drops `flash_sel` and abandons a load in progress. The next load starts again at word address 0.
- R11: Bytes presented on `rx_valid` outside a load produce no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; strap pins captured while low |
| mode_pins | input | 2 | Start-up strap value |
| dbg_req | input | 1 | Debugger request level, asynchronous |
| dbg_cmd | input | 3 | Debugger command code, stable while request is high |
| dbg_ack | output | 1 | Acknowledge returned to the debugger |
| rx_valid | input | 1 | One received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Header byte waiting to be sent to flash |
| tx_data | output | 8 | Header byte |
| tx_ack | input | 1 | Shifter has taken the header byte |
| flash_sel | output | 1 | Flash access in progress (select) |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_addr | output | 8 | Instruction word address |
| imem_wdata | output | 16 | Instruction word |
| core_run | output | 1 | Core runs freely |
| core_step | output | 1 | Core executes one instruction |
| core_halt | output | 1 | Core stopped |

## Verification
The bench uses the default parameters: a 512-byte image, a two-stage synchroniser and a three-byte flash address. With these values every load is a full image, so each path reaches the last word address and the end-of-image transition that starts or parks the core. The four-byte flash header is checked byte by byte against the stall that `tx_ack` imposes. The real two-stage handshake latency also lets commands be exercised in every state in which they must be obeyed or ignored.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_HALT,
      ST_RUN,
      ST_STEP,
      ST_SLV,
      ST_FHDR,
      ST_FDAT
   } seq_state_e;

   localparam logic [2:0] CMD_RESET = 3'd1;
   localparam logic [2:0] CMD_LOAD  = 3'd2;
   localparam logic [2:0] CMD_START = 3'd3;
   localparam logic [2:0] CMD_STEP  = 3'd4;
   localparam logic [2:0] CMD_STOP  = 3'd5;

   localparam logic [1:0] STRAP_SLAVE = 2'b01;
   localparam logic [1:0] STRAP_FLASH = 2'b10;

endpackage

// File: rtl/bootseq_cmd_sync.sv
module bootseq_cmd_sync #(
   parameter int SYNC_STAGES = 2,
   parameter int CMD_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_async,
   input  logic [CMD_W-1:0] cmd_async,
   output logic             req_rise,
   output logic [CMD_W-1:0] cmd_out,
   output logic             ack
);

   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("bootseq_cmd_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain  <= '0;
         seen_q <= 1'b0;
         ack    <= 1'b0;
      end else begin
         chain  <= {chain[SYNC_STAGES-2:0], req_async};
         seen_q <= chain[LAST];
         ack    <= chain[LAST];
      end
   end

   assign req_rise = chain[LAST] & ~seen_q;
   // The command bus is held steady by the debugger while its request is high.
   assign cmd_out  = cmd_async;

   assert_single_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_rise |=> !req_rise);

endmodule

// File: rtl/bootseq_img_loader.sv
module bootseq_img_loader #(
   parameter int BYTE_W    = 8,
   parameter int IMG_BYTES = 512
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      enable,
   input  logic                      rx_valid,
   input  logic [BYTE_W-1:0]         rx_data,
   output logic                      we,
   output logic [$clog2(IMG_BYTES)-2:0] waddr,
   output logic [2*BYTE_W-1:0]       wdata,
   output logic                      done
);

   localparam int CNT_W = $clog2(IMG_BYTES);
   localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(IMG_BYTES - 1);

   if ((IMG_BYTES < 4) || ((1 << CNT_W) != IMG_BYTES)) begin : g_bad_size
      $error("bootseq_img_loader: IMG_BYTES must be a power of two, at least 4");
   end

   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] hi_q;
   logic              take;

   assign take = enable & rx_valid;
   assign done = take & (cnt == LAST_BYTE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         hi_q  <= '0;
         we    <= 1'b0;
         waddr <= '0;
         wdata <= '0;
      end else begin
         we <= 1'b0;
         if (!enable) begin
            cnt <= '0;
         end else if (take) begin
            cnt <= cnt + 1'b1;
            if (!cnt[0]) begin
               hi_q <= rx_data;
            end else begin
               we    <= 1'b1;
               waddr <= cnt[CNT_W-1:1];
               wdata <= {hi_q, rx_data};
            end
         end
      end
   end

   assert_write_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we);

   assert_no_write_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> $past(enable));

endmodule

// File: rtl/bootseq_flash_hdr.sv
module bootseq_flash_hdr #(
   parameter int              BYTE_W     = 8,
   parameter int              ADDR_BYTES = 3,
   parameter logic [BYTE_W-1:0] RD_CMD   = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tx_ack,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   output logic              hdr_done
);

   localparam int IDX_W = $clog2(ADDR_BYTES + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES);

   if (ADDR_BYTES < 1) begin : g_bad_addr
      $error("bootseq_flash_hdr: ADDR_BYTES must be at least 1");
   end

   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         idx <= '0;
      end else if (tx_ack && (idx != LAST_IDX)) begin
         idx <= idx + 1'b1;
      end
   end

   assign tx_valid = active;
   assign tx_data  = (idx == '0) ? RD_CMD : '0;
   assign hdr_done = active & tx_ack & (idx == LAST_IDX);

   assert_hdr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ack) |=> (!tx_valid || $stable(tx_data)));

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl #(
   parameter int          BYTE_W      = 8,
   parameter int          IMG_BYTES   = 512,
   parameter int          SYNC_STAGES = 2,
   parameter int          ADDR_BYTES  = 3,
   parameter logic [7:0]  RD_CMD      = 8'h03
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    mode_pins,
   input  logic                          dbg_req,
   input  logic [2:0]                    dbg_cmd,
   output logic                          dbg_ack,
   input  logic                          rx_valid,
   input  logic [BYTE_W-1:0]             rx_data,
   output logic                          tx_valid,
   output logic [BYTE_W-1:0]             tx_data,
   input  logic                          tx_ack,
   output logic                          flash_sel,
   output logic                          imem_we,
   output logic [$clog2(IMG_BYTES)-2:0]  imem_addr,
   output logic [2*BYTE_W-1:0]           imem_wdata,
   output logic                          core_run,
   output logic                          core_step,
   output logic                          core_halt
);

   import bootseq_pkg::*;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("boot_seq_ctrl: the read command is an 8-bit value, BYTE_W must be 8");
   end

   seq_state_e st, st_n;
   logic       auto_q, auto_n;
   logic [1:0] strap_q;
   logic       cmd_rise;
   logic [2:0] cmd;
   logic       ld_done, hdr_done;

   bootseq_cmd_sync #(.SYNC_STAGES(SYNC_STAGES), .CMD_W(3)) u_sync (
      .clk(clk), .rst_n(rst_n), .req_async(dbg_req), .cmd_async(dbg_cmd),
      .req_rise(cmd_rise), .cmd_out(cmd), .ack(dbg_ack));

   bootseq_img_loader #(.BYTE_W(BYTE_W), .IMG_BYTES(IMG_BYTES)) u_load (
      .clk(clk), .rst_n(rst_n), .enable((st == ST_SLV) || (st == ST_FDAT)),
      .rx_valid(rx_valid), .rx_data(rx_data), .we(imem_we),
      .waddr(imem_addr), .wdata(imem_wdata), .done(ld_done));

   bootseq_flash_hdr #(.BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES), .RD_CMD(RD_CMD)) u_hdr (
      .clk(clk), .rst_n(rst_n), .active(st == ST_FHDR), .tx_ack(tx_ack),
      .tx_valid(tx_valid), .tx_data(tx_data), .hdr_done(hdr_done));

   always_comb begin
      st_n   = st;
      auto_n = auto_q;
      case (st)
         ST_BOOT: begin
            if (strap_q == STRAP_SLAVE) begin
               st_n   = ST_SLV;
               auto_n = 1'b1;
            end else if (strap_q == STRAP_FLASH) begin
               st_n   = ST_FHDR;
               auto_n = 1'b1;
            end else begin
               st_n   = ST_HALT;
            end
         end
         ST_HALT: begin
            if (cmd_rise) begin
               if (cmd == CMD_START)     st_n = ST_RUN;
               else if (cmd == CMD_STEP) st_n = ST_STEP;
               else if (cmd == CMD_LOAD) begin
                  st_n   = ST_SLV;
                  auto_n = 1'b0;
               end
            end
         end
         ST_RUN:  if (cmd_rise && (cmd == CMD_STOP)) st_n = ST_HALT;
         ST_STEP: st_n = ST_HALT;
         ST_FHDR: if (hdr_done) st_n = ST_FDAT;
         ST_SLV, ST_FDAT: if (ld_done) st_n = auto_q ? ST_RUN : ST_HALT;
         default: st_n = ST_HALT;
      endcase
      if (cmd_rise && (cmd == CMD_RESET) && (st != ST_BOOT)) st_n = ST_HALT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_BOOT;
         auto_q  <= 1'b0;
         strap_q <= mode_pins;
      end else begin
         st     <= st_n;
         auto_q <= auto_n;
      end
   end

   assign core_run  = (st == ST_RUN);
   assign core_step = (st == ST_STEP);
   assign core_halt = ~core_run;
   assign flash_sel = (st == ST_FHDR) || (st == ST_FDAT);

   assert_run_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_run) |-> ($past(cmd_rise) || $past(ld_done)));

   assert_step_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      core_step |=> (!core_step && !core_run));

   assert_reset_cmd_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rise && (cmd == CMD_RESET) && (st != ST_BOOT)) |=> (!core_run && !flash_sel));

   assert_sel_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flash_sel) |-> ($past(ld_done) || $past(cmd_rise)));

endmodule

// File: tb/boot_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module boot_seq_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_pins = 2'b00;
   logic        dbg_req = 1'b0;
   logic [2:0]  dbg_cmd = 3'd0;
   logic        dbg_ack;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'd0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ack = 1'b0;
   logic        flash_sel;
   logic        imem_we;
   logic [7:0]  imem_addr;
   logic [15:0] imem_wdata;
   logic        core_run, core_step, core_halt;

   int n_tests = 0;
   int n_fail  = 0;
   int wcount  = 0;
   int steps   = 0;
   int cycles  = 0;
   logic [15:0] mirror [0:255];

   always #2.5 clk = ~clk;

   boot_seq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
      .dbg_req(dbg_req), .dbg_cmd(dbg_cmd), .dbg_ack(dbg_ack),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ack(tx_ack),
      .flash_sel(flash_sel), .imem_we(imem_we), .imem_addr(imem_addr),
      .imem_wdata(imem_wdata), .core_run(core_run), .core_step(core_step),
      .core_halt(core_halt));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (imem_we) begin
         mirror[imem_addr] <= imem_wdata;
         wcount <= wcount + 1;
      end
      if (core_step) steps <= steps + 1;
   end

   // cmd code, expected run level, expected step pulses
   localparam logic [4:0] CMD_VEC [0:6] = '{
      {3'd3, 1'b1, 1'b0},   // R7 START from halted
      {3'd4, 1'b1, 1'b0},   // R8 STEP ignored while running
      {3'd5, 1'b0, 1'b0},   // R7 STOP
      {3'd4, 1'b0, 1'b1},   // R8 STEP gives one pulse
      {3'd7, 1'b0, 1'b0},   // R6 unused code does nothing
      {3'd3, 1'b1, 1'b0},   // R7 START again
      {3'd5, 1'b0, 1'b0}    // R7 STOP again
   };

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((i * 37 + seed * 11 + 3) & 255);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] m);
      @(negedge clk);
      rst_n = 1'b0;
      mode_pins = m;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      mode_pins = ~m;
      @(negedge clk);
   endtask

   task automatic send_cmd(input logic [2:0] c);
      @(negedge clk);
      dbg_cmd = c;
      dbg_req = 1'b1;
      for (int k = 0; k < 40 && !dbg_ack; k++) @(negedge clk);
      chk("R6 ack rises", int'(dbg_ack), 1);
      dbg_req = 1'b0;
      for (int k = 0; k < 40 && dbg_ack; k++) @(negedge clk);
      dbg_cmd = 3'd0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_image(input int seed);
      for (int i = 0; i < 512; i++) send_byte(pat(seed, i));
      @(negedge clk);
   endtask

   task automatic check_image(input string tag, input int seed);
      int bad = 0;
      for (int j = 0; j < 256; j++)
         if (mirror[j] !== {pat(seed, 2*j), pat(seed, 2*j+1)}) bad++;
      chk(tag, bad, 0);
   endtask

   initial begin
      while (cycles < 150000) @(negedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int w0, s0;
      // R1 strap 00: wait halted
      do_reset(2'b00);
      repeat (3) @(negedge clk);
      chk("R1 run after reset", int'(core_run), 0);
      chk("R1 halt after reset", int'(core_halt), 1);
      chk("R1 no flash select", int'(flash_sel), 0);
      chk("R6 ack idle", int'(dbg_ack), 0);

      // command table
      for (int v = 0; v < 7; v++) begin
         s0 = steps;
         send_cmd(CMD_VEC[v][4:2]);
         chk($sformatf("R7 vec%0d run", v), int'(core_run), int'(CMD_VEC[v][1]));
         chk($sformatf("R7 vec%0d halt", v), int'(core_halt), int'(!CMD_VEC[v][1]));
         chk($sformatf("R8 vec%0d steps", v), steps - s0, int'(CMD_VEC[v][0]));
      end

      // R11 bytes while halted
      w0 = wcount;
      for (int i = 0; i < 4; i++) send_byte(8'(i));
      chk("R11 no writes when idle", wcount - w0, 0);

      // R9 LOAD from halted
      w0 = wcount;
      send_cmd(3'd2);
      send_image(5);
      chk("R9 write count", wcount - w0, 256);
      check_image("R2 big-endian image", 5);
      chk("R9 stays halted", int'(core_run), 0);

      // R9 LOAD while running is ignored
      send_cmd(3'd3);
      w0 = wcount;
      send_cmd(3'd2);
      send_byte(8'hAA);
      send_byte(8'h55);
      chk("R9 load ignored while running", wcount - w0, 0);
      chk("R9 still running", int'(core_run), 1);
      send_cmd(3'd5);

      // R10 RESET abandons a load
      send_cmd(3'd2);
      for (int i = 0; i < 10; i++) send_byte(8'hF0);
      send_cmd(3'd1);
      chk("R10 halted after reset", int'(core_run), 0);
      w0 = wcount;
      send_byte(8'h12);
      send_byte(8'h34);
      chk("R10 load abandoned", wcount - w0, 0);
      send_cmd(3'd2);
      send_byte(pat(9, 0));
      send_byte(pat(9, 1));
      @(negedge clk);
      chk("R10 restart at address 0", int'(mirror[0]), int'({pat(9, 0), pat(9, 1)}));
      for (int i = 2; i < 512; i++) send_byte(pat(9, i));
      @(negedge clk);
      check_image("R10 full reload", 9);

      // R3 strap 01: slave load then run
      do_reset(2'b01);
      chk("R1 slave strap halted", int'(core_run), 0);
      chk("R1 slave strap no select", int'(flash_sel), 0);
      w0 = wcount;
      send_image(11);
      chk("R2 slave write count", wcount - w0, 256);
      check_image("R2 slave image", 11);
      chk("R3 auto run", int'(core_run), 1);

      // R4 / R5 strap 10: flash load
      do_reset(2'b10);
      chk("R1 flash strap select", int'(flash_sel), 1);
      for (int h = 0; h < 4; h++) begin
         repeat (2) @(negedge clk);
         chk($sformatf("R4 header %0d valid", h), int'(tx_valid), 1);
         chk($sformatf("R4 header %0d byte", h), int'(tx_data), (h == 0) ? 3 : 0);
         tx_ack = 1'b1;
         @(negedge clk);
         tx_ack = 1'b0;
      end
      @(negedge clk);
      chk("R4 header finished", int'(tx_valid), 0);
      chk("R5 select during data", int'(flash_sel), 1);
      w0 = wcount;
      send_image(13);
      chk("R2 flash write count", wcount - w0, 256);
      check_image("R2 flash image", 13);
      chk("R5 select released", int'(flash_sel), 0);
      chk("R3 flash auto run", int'(core_run), 1);

      // R1 strap 11 behaves as wait
      do_reset(2'b11);
      repeat (2) @(negedge clk);
      chk("R1 strap 11 halted", int'(core_run), 0);
      chk("R1 strap 11 no select", int'(flash_sel), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule